// File: doc/BRIEF.md
# Link Receiver-Detect Substate Sequencer

This block runs the receiver-detection stage of a serial link training state machine for up to four lanes. After reset it sits in a quiet substate, where the transmit lines are left to discharge. It then moves to an active substate, where it pulses a detect request to the PHY and waits for the PHY's completion pulse. That pulse carries a per-lane receiver-present vector. If an assigned lane reports a receiver, the block raises a go-to-polling indication and holds there. If no lane does, it goes back to quiet and waits the full interval again, so detection attempts never run back to back.

The quiet substate ends when a long timeout expires. It can end earlier when an assigned lane is seen out of electrical idle, but only once a programmable minimum dwell has passed. The dwell code is held in a small control register. Lanes that are not assigned to the link are forced to read as idle, so a lane used by another protocol cannot cut the wait short. Time is counted in microsecond ticks from a parameterized clock prescaler.

Top module: `det_substate_seq`

## Requirements
- R1: After reset, `substate` is 00 (quiet), `detReq` and `goPolling` are 0, and `cfgRdData` reads 0.
- R2: In the quiet substate the block leaves for the active substate once TIMEOUT_US microseconds have elapsed since it entered quiet, whatever the lanes show. One microsecond is US_DIV clock cycles.
- R3: An assigned lane with `laneIdle` low causes an early exit from quiet, but only once the elapsed quiet time is at least the active minimum dwell.
- R4: The minimum dwell is selected by `cfgRdData[2:1]`: 00 means no minimum, 01 means DWELL1_US (100 us by default), 10 means DWELL2_US (1 ms), and 11 means DWELL3_US (2 ms). The dwell applies from the cycle after it is written.
- R5: A write with `cfgWrEn` stores all CFG_W bits of `cfgWrData`, and they read back unchanged on `cfgRdData`. Only bits 2:1 affect behaviour.
- R6: A lane with `laneMask` bit 0 (unassigned) is treated as electrically idle. Its `laneIdle` value never causes an early exit from quiet.
- R7: On entering the active substate, `substate` reads 01 and `detReq` is high for exactly one cycle. The block then waits for `detDone` without issuing another request.
- R8: A `detDone` pulse whose `rxPresent` has no bit set on an assigned lane returns the block to quiet with its timers cleared, so the full quiet wait is applied again.
- R9: A `detDone` pulse with `rxPresent` set on an assigned lane moves the block to `substate` 10 with `goPolling` high, and it holds there. `rxPresent` bits of unassigned lanes are ignored.
- R10: `restart` returns the block from any substate to quiet with its timers cleared, on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneIdle | input | LANES | Per-lane electrical-idle status from the PHY (1 = idle) |
| laneMask | input | LANES | Lanes assigned to this link (1 = assigned) |
| detDone | input | 1 | One-cycle completion pulse of a receiver-detect operation |
| rxPresent | input | LANES | Per-lane receiver-present result, valid with `detDone` |
| restart | input | 1 | Return to the quiet substate and clear the timers |
| cfgWrEn | input | 1 | Write strobe for the control register |
| cfgWrData | input | CFG_W | Control register write data |
| detReq | output | 1 | One-cycle receiver-detect request to the PHY |
| substate | output | 2 | 00 quiet, 01 active, 10 polling |
| goPolling | output | 1 | A receiver was found on an assigned lane |
| cfgRdData | output | CFG_W | Control register contents |

## Verification
A wrong elapsed-time count or a wrong dwell decode shows at the ports as a `detReq` pulse that arrives too early or too late. The cycle-exact reference model flags this on the first cycle where `substate` differs, which is at the latest the cycle where the timeout should have fired. A lane mask that is lost or inverted shows either as an early exit caused by an unassigned lane or as a false `goPolling` caused by one. A timer that is not cleared after a failed attempt shows as a retry that comes sooner than the full quiet wait.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  typedef enum logic [1:0] {
    ST_QUIET  = 2'd0,
    ST_DETECT = 2'd1,
    ST_WAIT   = 2'd2,
    ST_POLL   = 2'd3
  } seqState_t;

  typedef struct packed {
    logic clrTimer;
    logic runTimer;
  } tmrCtl_t;

  localparam logic [1:0] SUB_QUIET  = 2'b00;
  localparam logic [1:0] SUB_ACTIVE = 2'b01;
  localparam logic [1:0] SUB_POLL   = 2'b10;
endpackage

// File: rtl/dsq_datapath.sv
module dsq_datapath
  import dsq_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int US_DIV     = 50,
  parameter int TIMEOUT_US = 12000,
  parameter int DWELL1_US  = 100,
  parameter int DWELL2_US  = 1000,
  parameter int DWELL3_US  = 2000,
  parameter int CFG_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrCtl_t          tmrCtl,
  input  logic [LANES-1:0] laneIdle,
  input  logic [LANES-1:0] laneMask,
  input  logic [LANES-1:0] rxPresent,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  output logic             timeoutHit,
  output logic             dwellMet,
  output logic             laneActive,
  output logic             rxFound
);
  localparam int PRE_W = (US_DIV > 2) ? $clog2(US_DIV) : 1;
  localparam int US_W  = $clog2(TIMEOUT_US + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(US_DIV - 1);
  localparam logic [US_W-1:0]  US_MAX   = US_W'(TIMEOUT_US);
  localparam logic [US_W-1:0]  LIM1     = US_W'(DWELL1_US);
  localparam logic [US_W-1:0]  LIM2     = US_W'(DWELL2_US);
  localparam logic [US_W-1:0]  LIM3     = US_W'(DWELL3_US);

  logic [PRE_W-1:0] preCnt;
  logic [US_W-1:0]  usCnt;
  logic [CFG_W-1:0] cfgReg;
  logic [US_W-1:0]  dwellLimit;
  logic [LANES-1:0] effIdle;

  // Unassigned lanes always read as idle
  for (genvar i = 0; i < LANES; i++) begin : gLaneMask
    assign effIdle[i] = laneIdle[i] | ~laneMask[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (cfgWrEn) begin
      cfgReg <= cfgWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || tmrCtl.clrTimer) begin
      preCnt <= '0;
      usCnt  <= '0;
    end else if (tmrCtl.runTimer) begin
      if (preCnt == PRE_LAST) begin
        preCnt <= '0;
        if (usCnt != US_MAX) usCnt <= usCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (cfgReg[2:1])
      2'b00:   dwellLimit = '0;
      2'b01:   dwellLimit = LIM1;
      2'b10:   dwellLimit = LIM2;
      default: dwellLimit = LIM3;
    endcase
  end

  assign cfgRdData  = cfgReg;
  assign timeoutHit = (usCnt >= US_MAX);
  assign dwellMet   = (usCnt >= dwellLimit);
  assign laneActive = |(~effIdle);
  assign rxFound    = |(rxPresent & laneMask);
endmodule

// File: rtl/dsq_control.sv
module dsq_control
  import dsq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      restart,
  input  logic      timeoutHit,
  input  logic      dwellMet,
  input  logic      laneActive,
  input  logic      detDone,
  input  logic      rxFound,
  output tmrCtl_t   tmrCtl,
  output seqState_t state
);
  seqState_t nextState;

  always_comb begin
    nextState       = state;
    tmrCtl.clrTimer = 1'b0;
    tmrCtl.runTimer = (state == ST_QUIET);
    if (restart) begin
      nextState       = ST_QUIET;
      tmrCtl.clrTimer = 1'b1;
    end else begin
      unique case (state)
        ST_QUIET: begin
          if (timeoutHit || (dwellMet && laneActive)) nextState = ST_DETECT;
        end
        ST_DETECT: nextState = ST_WAIT;
        ST_WAIT: begin
          if (detDone) begin
            if (rxFound) begin
              nextState = ST_POLL;
            end else begin
              nextState       = ST_QUIET;
              tmrCtl.clrTimer = 1'b1;
            end
          end
        end
        default: nextState = ST_POLL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_QUIET;
    else       state <= nextState;
  end
endmodule

// File: rtl/det_substate_seq.sv
module det_substate_seq
  import dsq_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int US_DIV     = 50,
  parameter int TIMEOUT_US = 12000,
  parameter int DWELL1_US  = 100,
  parameter int DWELL2_US  = 1000,
  parameter int DWELL3_US  = 2000,
  parameter int CFG_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] laneIdle,
  input  logic [LANES-1:0] laneMask,
  input  logic             detDone,
  input  logic [LANES-1:0] rxPresent,
  input  logic             restart,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic             detReq,
  output logic [1:0]       substate,
  output logic             goPolling,
  output logic [CFG_W-1:0] cfgRdData
);
  tmrCtl_t   tmrCtl;
  seqState_t state;
  logic      timeoutHit, dwellMet, laneActive, rxFound;

  dsq_datapath #(
    .LANES(LANES), .US_DIV(US_DIV), .TIMEOUT_US(TIMEOUT_US),
    .DWELL1_US(DWELL1_US), .DWELL2_US(DWELL2_US), .DWELL3_US(DWELL3_US),
    .CFG_W(CFG_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .tmrCtl(tmrCtl),
    .laneIdle(laneIdle), .laneMask(laneMask), .rxPresent(rxPresent),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .timeoutHit(timeoutHit), .dwellMet(dwellMet),
    .laneActive(laneActive), .rxFound(rxFound)
  );

  dsq_control uCtl (
    .clk(clk), .rstN(rstN), .restart(restart),
    .timeoutHit(timeoutHit), .dwellMet(dwellMet), .laneActive(laneActive),
    .detDone(detDone), .rxFound(rxFound),
    .tmrCtl(tmrCtl), .state(state)
  );

  always_comb begin
    unique case (state)
      ST_QUIET: substate = SUB_QUIET;
      ST_POLL:  substate = SUB_POLL;
      default:  substate = SUB_ACTIVE;
    endcase
  end

  assign detReq    = (state == ST_DETECT);
  assign goPolling = (state == ST_POLL);
endmodule

// File: rtl/dsq_checker.sv
module dsq_checker #(
  parameter int LANES      = 4,
  parameter int US_DIV     = 50,
  parameter int TIMEOUT_US = 12000,
  parameter int DWELL1_US  = 100,
  parameter int DWELL2_US  = 1000,
  parameter int DWELL3_US  = 2000,
  parameter int CFG_W      = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [LANES-1:0] laneIdle,
  input logic [LANES-1:0] laneMask,
  input logic             detDone,
  input logic [LANES-1:0] rxPresent,
  input logic             restart,
  input logic             detReq,
  input logic [1:0]       substate,
  input logic             goPolling,
  input logic [CFG_W-1:0] cfgRdData
);
  localparam int TO_CYC = TIMEOUT_US * US_DIV;

  int quietCyc;
  int dwellCyc;

  always_ff @(posedge clk) begin
    if (!rstN) quietCyc <= 0;
    else if (substate == 2'b00 && !restart && quietCyc < TO_CYC) quietCyc <= quietCyc + 1;
    else if (substate == 2'b00 && !restart) quietCyc <= quietCyc;
    else quietCyc <= 0;
  end

  always_comb begin
    case (cfgRdData[2:1])
      2'b00:   dwellCyc = 0;
      2'b01:   dwellCyc = DWELL1_US * US_DIV;
      2'b10:   dwellCyc = DWELL2_US * US_DIV;
      default: dwellCyc = DWELL3_US * US_DIV;
    endcase
  end

  assert_timeout_exit_R2: assert property (@(posedge clk) disable iff (!rstN)
    (substate == 2'b00 && !restart && quietCyc >= TO_CYC) |=> detReq);

  assert_dwell_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (substate == 2'b00 && quietCyc < dwellCyc) |=> (substate == 2'b00));

  assert_mask_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (substate == 2'b00 && quietCyc < TO_CYC && ((~laneIdle) & laneMask) == '0)
      |=> (substate == 2'b00));

  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (detReq && !restart) |=> (!detReq && substate == 2'b01));

  assert_retry_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (substate == 2'b01 && !detReq && detDone && (rxPresent & laneMask) == '0 && !restart)
      |=> (substate == 2'b00 && !detReq));

  assert_poll_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (goPolling && !restart) |=> goPolling);

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (substate == 2'b00 && !goPolling && !detReq));
endmodule

bind det_substate_seq dsq_checker #(
  .LANES(LANES), .US_DIV(US_DIV), .TIMEOUT_US(TIMEOUT_US),
  .DWELL1_US(DWELL1_US), .DWELL2_US(DWELL2_US), .DWELL3_US(DWELL3_US),
  .CFG_W(CFG_W)
) uChk (
  .clk(clk), .rstN(rstN), .laneIdle(laneIdle), .laneMask(laneMask),
  .detDone(detDone), .rxPresent(rxPresent), .restart(restart),
  .detReq(detReq), .substate(substate), .goPolling(goPolling),
  .cfgRdData(cfgRdData)
);

// File: tb/sim_det_substate_seq.sv
module sim_det_substate_seq;
  localparam int LANES = 4;
  localparam int D     = 2;
  localparam int TO    = 60;
  localparam int DW1   = 5;
  localparam int DW2   = 20;
  localparam int DW3   = 40;
  localparam int CW    = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [LANES-1:0] laneIdle = '1;
  logic [LANES-1:0] laneMask = 4'h3;
  logic             detDone = 1'b0;
  logic [LANES-1:0] rxPresent = '0;
  logic             restart = 1'b0;
  logic             cfgWrEn = 1'b0;
  logic [CW-1:0]    cfgWrData = '0;
  logic             detReq;
  logic [1:0]       substate;
  logic             goPolling;
  logic [CW-1:0]    cfgRdData;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  det_substate_seq #(
    .LANES(LANES), .US_DIV(D), .TIMEOUT_US(TO),
    .DWELL1_US(DW1), .DWELL2_US(DW2), .DWELL3_US(DW3), .CFG_W(CW)
  ) u0 (
    .clk(clk), .rstN(rstN), .laneIdle(laneIdle), .laneMask(laneMask),
    .detDone(detDone), .rxPresent(rxPresent), .restart(restart),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .detReq(detReq),
    .substate(substate), .goPolling(goPolling), .cfgRdData(cfgRdData)
  );

  // Behavioural reference: 0 quiet, 1 request, 2 awaiting result, 3 polling
  int mSt = 0;
  int mCyc = 0;
  int mCfg = 0;

  function automatic int dwellUs(int code);
    case (code)
      0: return 0;
      1: return DW1;
      2: return DW2;
      default: return DW3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mCyc = 0; mCfg = 0;
    end else begin
      if (restart) begin
        mSt = 0; mCyc = 0;
      end else begin
        case (mSt)
          0: begin
            if ((mCyc / D) >= TO ||
                ((mCyc / D) >= dwellUs((mCfg >> 1) & 3) && (((~laneIdle) & laneMask) != 0)))
              mSt = 1;
            else
              mCyc = mCyc + 1;
          end
          1: mSt = 2;
          2: if (detDone) begin
               if ((rxPresent & laneMask) != 0) mSt = 3;
               else begin mSt = 0; mCyc = 0; end
             end
          default: mSt = 3;
        endcase
      end
      if (cfgWrEn) mCfg = int'(cfgWrData);
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      int expSub;
      expSub = (mSt == 0) ? 0 : (mSt == 3) ? 2 : 1;
      check(int'(substate) == expSub, {curReq, " substate"}, int'(substate), expSub);
      check(detReq == (mSt == 1), {curReq, " detReq"}, int'(detReq), int'(mSt == 1));
      check(goPolling == (mSt == 3), {curReq, " goPolling"}, int'(goPolling), int'(mSt == 3));
      check(int'(cfgRdData) == mCfg, {curReq, " cfgRdData"}, int'(cfgRdData), mCfg);
    end
  end

  task automatic finishRun();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  // Wait for a detect request; returns the cycles waited
  task automatic waitReq(string req, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!detReq && n < 1000);
    check(detReq == 1'b1, {req, " request seen"}, int'(detReq), 1);
  endtask

  task automatic respond(logic [LANES-1:0] rx);
    @(negedge clk);
    detDone = 1'b1; rxPresent = rx;
    @(negedge clk);
    detDone = 1'b0; rxPresent = '0;
  endtask

  task automatic writeCfg(logic [CW-1:0] v);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWrData = '0;
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    check(substate == 2'b00 && !detReq && !goPolling && cfgRdData == '0,
          "R1 reset state", int'(substate), 0);
    rstN = 1'b1;

    // R2: all idle, no dwell, quiet ends on timeout
    curReq = "R2";
    waitReq("R2", n);
    check(n >= TO * D, "R2 timeout wait", n, TO * D + 1);
    // R8: failed detect, full wait again
    curReq = "R8";
    respond(4'h0);
    waitReq("R8", n);
    check(n >= TO * D, "R8 full wait on retry", n, TO * D);
    respond(4'h0);

    // R4/R5: code 11 in bits 2:1, other bits kept; lane 0 active
    curReq = "R5";
    writeCfg(8'hA6);
    check(cfgRdData == 8'hA6, "R5 readback", int'(cfgRdData), 8'hA6);
    curReq = "R4";
    laneIdle = 4'hE;
    waitReq("R4", n);
    check(n >= DW3 * D && n < TO * D, "R4 early exit after 2ms-class dwell", n, DW3 * D);
    respond(4'h0);
    laneIdle = 4'hF;

    // R6: only unassigned lane 3 leaves idle
    curReq = "R6";
    writeCfg(8'h02);
    laneIdle = 4'h7;
    waitReq("R6", n);
    check(n >= TO * D, "R6 unassigned lane ignored", n, TO * D);
    respond(4'h0);

    // R3: no minimum dwell, assigned lane 1 active
    curReq = "R3";
    writeCfg(8'h00);
    laneIdle = 4'hD;
    waitReq("R3", n);
    check(n < 4, "R3 immediate early exit", n, 1);
    // R9: receiver on unassigned lanes only is a failed attempt
    curReq = "R9";
    respond(4'hC);
    check(!goPolling, "R9 unassigned rxPresent ignored", int'(goPolling), 0);
    waitReq("R9", n);
    // R7: request lasts one cycle
    @(negedge clk);
    check(!detReq && substate == 2'b01, "R7 single-cycle request", int'(detReq), 0);
    detDone = 1'b1; rxPresent = 4'h2;
    @(negedge clk);
    detDone = 1'b0; rxPresent = '0;
    laneIdle = 4'hF;
    repeat (10) @(negedge clk);
    check(goPolling && substate == 2'b10, "R9 polling held", int'(substate), 2);

    // R10: restart from polling
    curReq = "R10";
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check(substate == 2'b00 && !goPolling, "R10 back to quiet", int'(substate), 0);
    waitReq("R10", n);
    check(n >= TO * D, "R10 timers cleared", n, TO * D);
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule